// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block drives four PWM pins from one shared period counter. A power-of-two prescaler divides the system clock into count ticks. On each tick the 15-bit counter steps under one of two counting schemes. In edge-aligned mode it climbs from zero to the top value and then restarts at zero. In center-aligned mode it climbs to the top value and then walks back down to zero. Each channel drives its pin active while the counter is below that channel's compare value. A per-channel polarity bit sets whether active means high or low.

Software-side writes go into pending registers. These are the top value, the counting mode and, for each channel, the compare value and polarity. The block moves them into the working set only when a period closes, so a period never mixes old and new settings. While the block is disabled, the working set follows the pending set continuously and the counter is held at zero. The pins freeze at whatever level they last drove. A one-cycle pulse marks the close of every period, so that a sequence player can pace its updates.

Top module: `pwm4_gen`

## Requirements
- R1: While reset is asserted, all four pins and the period pulse read 0.
- R2: The prescaler code p (0..7) yields one count tick every 2^p system clocks. An edge-aligned period with top T therefore lasts (T+1)*2^p clocks.
- R3: A top input above 32767 is treated as 32767. With top_val = 16'hFFFF and p = 0, an edge-aligned period lasts 32768 clocks.
- R4: With center = 0, the counter runs 0,1,..,T and then returns to 0. period_end pulses for one clock once per period, registered on the wrap to 0.
- R5: With center = 1, the counter runs 0..T and back to 0, so a period lasts 2T ticks. period_end pulses when the counter arrives back at 0. With T = 0, every tick closes a period.
- R6: A channel is active while counter < compare. The pin equals the active level XOR the channel's polarity bit (polarity 1 inverts the pin). The pin is registered, one clock after the counter value it reflects.
- R7: A compare value of 0 keeps the pin at its inactive level (the polarity bit). A nonzero compare at or above the top keeps it at its active level for the whole period.
- R8: While enabled, a change to top, mode, compare or polarity reaches the working set only on the clock that closes a period. A load on that same clock is included.
- R9: With en low, the pins hold their last levels, period_end stays 0 and the counter holds at 0. Pending values load directly into the working set, so they apply from the first cycle after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable |
| center | input | 1 | 0 = edge-aligned counting, 1 = center-aligned counting (pending) |
| psc | input | 3 | Prescaler code p, tick every 2^p clocks (live) |
| top_val | input | 16 | Counter top, saturated to 32767 (pending) |
| cmp_val | input | 15 | Compare value for the channels selected by cmp_load |
| cmp_pol | input | 1 | Polarity for the channels selected by cmp_load |
| cmp_load | input | 4 | Per-channel load strobe, bit i writes channel i's pending compare and polarity |
| pwm_out | output | 4 | PWM pins, bit i is channel i |
| period_end | output | 1 | One-clock pulse at each period close |

## Verification
A corrupted counter or direction bit shows first as a period_end pulse at the wrong time, and all four duty patterns shift with it within one period. A stale or early-loaded shadow register shows up as a high count that differs from the expected value during the period when a write arrives. The bench compares every pin and the pulse on every cycle against a cycle model built from these requirements, so a divergence is reported on the clock where it first reaches the ports. Directed windows measure period lengths and per-channel high counts for the exact values given above.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int unsigned CNT_W = 15;
  localparam int unsigned N_CH  = 4;
  localparam int unsigned PSC_W = 3;

  typedef enum logic {
    CNT_EDGE   = 1'b0,
    CNT_CENTER = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/pwm4_tick_div.sv
module pwm4_tick_div #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // low p bits all ones marks the last clock of a 2^p group
  always_comb mask = ~({DIV_W{1'b1}} << psc);

  assign tick = en && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !en) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm4_period_cnt.sv
module pwm4_period_cnt
  import pwm4_pkg::*;
#(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  cnt_mode_e     mode,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          bnd
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dn_q, dn_d;
  logic          wrap;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    wrap  = 1'b0;
    if (mode == CNT_EDGE) begin
      dn_d = 1'b0;
      if (cnt_q >= top) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (top == '0) begin
      cnt_d = '0;
      dn_d  = 1'b0;
      wrap  = 1'b1;
    end else if (!dn_q && (cnt_q < top)) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
      dn_d  = 1'b1;
      if (cnt_d == '0) begin
        dn_d = 1'b0;
        wrap = 1'b1;
      end
    end
  end

  assign bnd = tick && wrap;
  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end
endmodule

// File: rtl/pwm4_shadow.sv
module pwm4_shadow
  import pwm4_pkg::*;
#(
  parameter int CW  = 15,
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    bnd,
  input  logic                    center_i,
  input  logic [CW:0]             top_i,
  input  logic [CW-1:0]           cmp_i,
  input  logic                    pol_i,
  input  logic [NCH-1:0]          load_i,
  output cnt_mode_e               act_mode,
  output logic [CW-1:0]           act_top,
  output logic [NCH-1:0][CW-1:0]  act_cmp,
  output logic [NCH-1:0]          act_pol
);
  localparam logic [CW:0] TOP_MAX = {1'b0, {CW{1'b1}}};

  logic [NCH-1:0][CW-1:0] pend_cmp_q, pend_cmp_d;
  logic [NCH-1:0]         pend_pol_q, pend_pol_d;
  logic [CW-1:0]          top_sat;
  logic                   take;

  assign top_sat = (top_i > TOP_MAX) ? TOP_MAX[CW-1:0] : top_i[CW-1:0];
  assign take    = !en || bnd;

  for (genvar i = 0; i < NCH; i++) begin : g_pend
    always_comb begin
      pend_cmp_d[i] = load_i[i] ? cmp_i : pend_cmp_q[i];
      pend_pol_d[i] = load_i[i] ? pol_i : pend_pol_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cmp_q <= '0;
      pend_pol_q <= '0;
      act_cmp    <= '0;
      act_pol    <= '0;
      act_top    <= '0;
      act_mode   <= CNT_EDGE;
    end else begin
      pend_cmp_q <= pend_cmp_d;
      pend_pol_q <= pend_pol_d;
      if (take) begin
        act_cmp  <= pend_cmp_d;
        act_pol  <= pend_pol_d;
        act_top  <= top_sat;
        act_mode <= center_i ? CNT_CENTER : CNT_EDGE;
      end
    end
  end
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] top,
  input  logic [CW-1:0] cmp,
  input  logic          pol,
  output logic          pin
);
  logic active;

  assign active = (cmp != '0) && ((cmp >= top) || (cnt < cmp));

  always_ff @(posedge clk) begin
    if (rst)     pin <= 1'b0;
    else if (en) pin <= active ^ pol;
  end
endmodule

// File: rtl/pwm4_gen.sv
module pwm4_gen
  import pwm4_pkg::*;
#(
  parameter int CW    = CNT_W,
  parameter int NCH   = N_CH,
  parameter int PSC_W = pwm4_pkg::PSC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             center,
  input  logic [PSC_W-1:0] psc,
  input  logic [CW:0]      top_val,
  input  logic [CW-1:0]    cmp_val,
  input  logic             cmp_pol,
  input  logic [NCH-1:0]   cmp_load,
  output logic [NCH-1:0]   pwm_out,
  output logic             period_end
);
  logic                   tick;
  logic                   bnd;
  logic [CW-1:0]          cnt_q;
  cnt_mode_e              act_mode;
  logic [CW-1:0]          act_top;
  logic [NCH-1:0][CW-1:0] act_cmp;
  logic [NCH-1:0]         act_pol;

  pwm4_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .en(en), .psc(psc), .tick(tick)
  );

  pwm4_period_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .mode(act_mode),
    .top(act_top), .cnt(cnt_q), .bnd(bnd)
  );

  pwm4_shadow #(.CW(CW), .NCH(NCH)) u_shd (
    .clk(clk), .rst(rst), .en(en), .bnd(bnd), .center_i(center),
    .top_i(top_val), .cmp_i(cmp_val), .pol_i(cmp_pol), .load_i(cmp_load),
    .act_mode(act_mode), .act_top(act_top), .act_cmp(act_cmp), .act_pol(act_pol)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm4_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .en(en), .cnt(cnt_q), .top(act_top),
      .cmp(act_cmp[i]), .pol(act_pol[i]), .pin(pwm_out[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) period_end <= 1'b0;
    else     period_end <= bnd;
  end
endmodule

// File: rtl/pwm4_gen_chk.sv
module pwm4_gen_chk #(
  parameter int CW  = 15,
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic [NCH-1:0]         pwm_out,
  input logic                   period_end,
  input logic [CW-1:0]          cnt,
  input logic [CW-1:0]          act_top,
  input logic [NCH-1:0][CW-1:0] act_cmp,
  input logic [NCH-1:0]         act_pol,
  input logic                   bnd
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      p_reset_quiet_r1: assert (pwm_out == '0 && !period_end)
        else $error("R1 outputs not cleared in reset");
    end
  end

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= act_top));

  p_pulse_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    period_end |-> (cnt == '0));

  p_off_no_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !period_end);

  p_off_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pwm_out));

  p_shadow_top_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !bnd) |=> $stable(act_top));

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    p_zero_cmp_r7: assert property (@(posedge clk) disable iff (rst)
      (en && act_cmp[i] == '0) |=> (pwm_out[i] == $past(act_pol[i])));

    p_full_cmp_r7: assert property (@(posedge clk) disable iff (rst)
      (en && act_cmp[i] != '0 && act_cmp[i] >= act_top)
        |=> (pwm_out[i] != $past(act_pol[i])));
  end
endmodule

bind pwm4_gen pwm4_gen_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pwm_out(pwm_out), .period_end(period_end),
  .cnt(cnt_q), .act_top(act_top), .act_cmp(act_cmp), .act_pol(act_pol), .bnd(bnd)
);

// File: tb/sim_pwm4_gen.sv
`timescale 1ns/100ps
module sim_pwm4_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        center = 1'b0;
  logic [2:0]  psc = 3'd0;
  logic [15:0] top_val = 16'd0;
  logic [14:0] cmp_val = 15'd0;
  logic        cmp_pol = 1'b0;
  logic [3:0]  cmp_load = 4'd0;
  logic [3:0]  pwm_out;
  logic        period_end;

  int    n_chk = 0;
  int    n_err = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwm4_gen u0 (
    .clk(clk), .rst(rst), .en(en), .center(center), .psc(psc),
    .top_val(top_val), .cmp_val(cmp_val), .cmp_pol(cmp_pol),
    .cmp_load(cmp_load), .pwm_out(pwm_out), .period_end(period_end)
  );

  // cycle model written from the requirements
  int   m_div, m_cnt, m_top;
  bit   m_dn, m_mode, m_pe;
  int   m_pcmp[4], m_acmp[4];
  bit   m_ppol[4], m_apol[4];
  logic [3:0] m_pin;

  always @(posedge clk) begin : model
    int  msk, nc;
    bit  tk, w, nd, act;
    if (rst) begin
      m_div = 0; m_cnt = 0; m_top = 0; m_dn = 0; m_mode = 0; m_pe = 0;
      m_pin = '0;
      for (int c = 0; c < 4; c++) begin
        m_pcmp[c] = 0; m_acmp[c] = 0; m_ppol[c] = 0; m_apol[c] = 0;
      end
    end else begin
      msk = (1 << psc) - 1;
      tk  = en && ((m_div & msk) == msk);
      if (!m_mode) begin
        w = (m_cnt == m_top); nc = w ? 0 : m_cnt + 1; nd = 0;
      end else if (m_top == 0) begin
        w = 1; nc = 0; nd = 0;
      end else if (!m_dn && m_cnt != m_top) begin
        w = 0; nc = m_cnt + 1; nd = 0;
      end else begin
        nc = m_cnt - 1; w = (nc == 0); nd = !w;
      end
      for (int c = 0; c < 4; c++) begin
        act = (m_acmp[c] != 0) && (m_acmp[c] >= m_top || m_cnt < m_acmp[c]);
        if (en) m_pin[c] = act ^ m_apol[c];
      end
      m_pe = tk && w;
      for (int c = 0; c < 4; c++)
        if (cmp_load[c]) begin m_pcmp[c] = cmp_val; m_ppol[c] = cmp_pol; end
      if (!en || (tk && w)) begin
        for (int c = 0; c < 4; c++) begin m_acmp[c] = m_pcmp[c]; m_apol[c] = m_ppol[c]; end
        m_top  = (top_val > 16'd32767) ? 32767 : int'(top_val);
        m_mode = center;
      end
      if (!en) begin m_cnt = 0; m_dn = 0; end
      else if (tk) begin m_cnt = nc; m_dn = nd; end
      m_div = en ? ((m_div + 1) & 127) : 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "pins vs model", int'(pwm_out), int'(m_pin));
      chk(cur_req, "period_end vs model", int'(period_end), int'(m_pe));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_err++;
      $display("FAIL R2 watchdog: actual %0d cycles expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_ch(int ch, int val, bit pol);
    step();
    cmp_val = 15'(val); cmp_pol = pol; cmp_load = 4'b0001 << ch;
    step();
    cmp_load = '0;
  endtask

  task automatic period_len(output int n);
    n = 0;
    do @(negedge clk); while (!period_end);
    do begin @(negedge clk); n++; end while (!period_end && n < 70000);
  endtask

  task automatic count_high(input int len, input int ld_at, input int ld_ch,
                            input int ld_val, output int h[4]);
    for (int c = 0; c < 4; c++) h[c] = 0;
    do @(negedge clk); while (!period_end);
    for (int i = 0; i < len; i++) begin
      step();
      if (i == ld_at) begin
        cmp_val = 15'(ld_val); cmp_pol = 1'b0; cmp_load = 4'b0001 << ld_ch;
      end else cmp_load = '0;
      @(negedge clk);
      for (int c = 0; c < 4; c++) h[c] += int'(pwm_out[c]);
    end
  endtask

  initial begin
    int n;
    int h[4];
    logic [3:0] held;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    chk("R1", "pins in reset", int'(pwm_out), 0);
    chk("R1", "period_end in reset", int'(period_end), 0);
    step(); rst = 1'b0;

    // R4 edge-aligned wrap
    cur_req = "R4";
    load_ch(0, 2, 0); load_ch(1, 3, 0); load_ch(2, 4, 0); load_ch(3, 1, 1);
    step(); top_val = 16'd4; center = 0; psc = 3'd0; en = 1;
    period_len(n); chk("R4", "edge period T=4", n, 5);

    // R2 prescaler
    cur_req = "R2";
    step(); psc = 3'd2; top_val = 16'd3;
    period_len(n); chk("R2", "period T=3 p=2", n, 16);
    step(); psc = 3'd7; top_val = 16'd1;
    period_len(n); chk("R2", "period T=1 p=7", n, 256);

    // R5 center-aligned
    cur_req = "R5";
    step(); psc = 3'd0; center = 1; top_val = 16'd4;
    period_len(n); chk("R5", "center period T=4", n, 8);
    step(); top_val = 16'd1;
    period_len(n); chk("R5", "center period T=1", n, 2);
    step(); top_val = 16'd0;
    period_len(n); chk("R5", "center period T=0", n, 1);

    // R6 / R7 duty patterns, edge T=9
    cur_req = "R6";
    step(); center = 0; top_val = 16'd9;
    load_ch(0, 0, 0); load_ch(1, 3, 0); load_ch(2, 9, 0); load_ch(3, 3, 1);
    count_high(10, -1, 0, 0, h);
    count_high(10, -1, 0, 0, h);
    chk("R7", "ch0 cmp=0 high count", h[0], 0);
    chk("R6", "ch1 cmp=3 high count", h[1], 3);
    chk("R7", "ch2 cmp=top high count", h[2], 10);
    chk("R6", "ch3 cmp=3 inverted high count", h[3], 7);

    // center T=8
    step(); center = 1; top_val = 16'd8;
    count_high(16, -1, 0, 0, h);
    count_high(16, -1, 0, 0, h);
    chk("R7", "center ch0 cmp=0", h[0], 0);
    chk("R6", "center ch1 cmp=3", h[1], 5);
    chk("R7", "center ch2 cmp>top", h[2], 16);

    // R8 shadowing of a compare written mid-period
    cur_req = "R8";
    step(); center = 0; top_val = 16'd9;
    count_high(10, -1, 0, 0, h);
    count_high(10, -1, 0, 0, h);
    count_high(10, 3, 1, 7, h);
    chk("R8", "ch1 keeps old compare this period", h[1], 3);
    count_high(10, -1, 0, 0, h);
    chk("R8", "ch1 new compare next period", h[1], 7);

    // R3 saturation
    cur_req = "R3";
    step(); top_val = 16'hFFFF;
    period_len(n); chk("R3", "saturated period", n, 32768);

    // R9 disable holds pins
    cur_req = "R9";
    step(); top_val = 16'd5;
    load_ch(3, 0, 1);
    period_len(n); period_len(n);
    step(); en = 0;
    @(negedge clk); held = pwm_out;
    chk("R9", "ch3 held high level", int'(held[3]), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 19) begin
        chk("R9", "pins frozen while off", int'(pwm_out), int'(held));
        chk("R9", "no pulse while off", int'(period_end), 0);
      end
    end
    load_ch(3, 0, 0);
    step(); en = 1;
    @(negedge clk); @(negedge clk);
    chk("R9", "pending polarity applied at enable", int'(pwm_out[3]), 0);

    // random mix, checked every cycle against the model
    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      step();
      en = ($urandom % 60) != 0;
      if ($urandom % 40 == 0) center = $urandom % 2;
      if ($urandom % 40 == 0) psc = 3'($urandom % 3);
      if ($urandom % 30 == 0) top_val = 16'($urandom % 24);
      if ($urandom % 200 == 0) top_val = 16'h8000 | 16'($urandom % 16);
      if ($urandom % 4 == 0) begin
        cmp_load = 4'($urandom);
        cmp_val  = 15'($urandom % 30);
        cmp_pol  = $urandom % 2;
      end else cmp_load = '0;
      if (top_val > 16'd40 && $urandom % 3 == 0) top_val = 16'd7;
    end
    step(); cmp_load = '0;
    repeat (5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule